// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Controller

This block turns single requests from a 16-bit core into bus cycles on a shared address/data pin set. Each cycle starts with an address clock in which an address-latch-enable output is high, so an external transparent latch can catch the address. The strobe phase follows, in which the same pins carry write data or are released to receive read data. The cycle closes with one clock in which the strobes are high again, a done pulse is raised and read data is handed back to the core.

A byte-mode input chooses the external data width. With a 16-bit bus the low pin group carries the even-address byte and the high group the odd-address byte. With an 8-bit bus every data byte moves on the low group, and the high group keeps driving the upper address byte. The strobe phase can be lengthened by a configured number of wait clocks, and it is frozen while the ready input is low. Five active-low chip selects come from a base/mask compare on the upper address bits. A control bit holds all strobes high for accesses that the core marks as internal.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is high and in the idle state: ale is 0, rd_n, wel_n and weh_n are 1, every cs_n bit is 1, pad_oe is 2'b00, pad_out is 0 and done is 0.
- R2: A request is accepted on a clock edge while the block is idle and req_valid is 1. In the next clock ale is 1 and all strobes are high. The strobe phase follows it. The last clock has strobes high, ale 0 and done 1. With no waits and ready high, done comes 3 clocks after the accepting edge.
- R3: In the address clock both pin groups are driven (pad_oe = 2'b11): pad_out[7:0] = addr[7:0] and pad_out[15:8] = addr[15:8].
- R4: On a 16-bit bus (byte_mode = 0), wel_n is low during the strobe phase when req_be[0] is 1 and weh_n is low when req_be[1] is 1. So be 2'b01 is an even byte, 2'b10 an odd byte and 2'b11 a word.
- R5: On an 8-bit bus (byte_mode = 1), weh_n stays high. wel_n is low during the write strobe phase. The high group drives addr[15:8] from the address clock to the end clock. On writes the low group carries wdata[15:8] when be = 2'b10 and wdata[7:0] otherwise.
- R6: On a 16-bit read, pad_oe is 2'b00 in the strobe and end clocks. rd_data equals pad_in as sampled on the last strobe clock edge.
- R7: On an 8-bit read, pad_oe is 2'b10 in the strobe and end clocks. rd_data is {pad_in[7:0], 8'h00} when be = 2'b10 and {8'h00, pad_in[7:0]} otherwise.
- R8: With quiet_int = 1, an access with req_internal = 1 keeps rd_n, wel_n and weh_n high throughout. An internal read always returns rd_data = 0, whatever pad_in holds.
- R9: The strobe phase gets extra clocks: 1 when wait_one = 1, 2 when wait_one = 0 and rdy_samp = 1, and none otherwise.
- R10: On every strobe-phase edge where rdy is 0, including wait clocks, the cycle stays in the strobe phase with the strobes unchanged. Each such edge adds one clock.
- R11: cs_n[i] is low from the address clock to the end clock when ((addr[15:12] ^ base_i) & mask_i) == 0, where base_i and mask_i are bits [4i+3:4i] of cs_base and cs_mask. Every cs_n bit is high while idle.
- R12: On a 16-bit write, both groups drive req_wdata (pad_oe = 2'b11) in the strobe and end clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request, held until done |
| req_addr | input | 16 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 even byte, bit 1 odd byte |
| req_wdata | input | 16 | Write data |
| req_internal | input | 1 | Access targets internal memory |
| byte_mode | input | 1 | 1 = 8-bit external bus |
| quiet_int | input | 1 | Hold strobes high on internal accesses |
| wait_one | input | 1 | Add one wait clock |
| rdy_samp | input | 1 | With wait_one low, add two wait clocks |
| rdy | input | 1 | Ready; low freezes the strobe phase |
| cs_base | input | 20 | Five 4-bit region bases |
| cs_mask | input | 20 | Five 4-bit region masks |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wel_n | output | 1 | Low-byte write strobe, active low |
| weh_n | output | 1 | High-byte write strobe, active low |
| cs_n | output | 5 | Chip selects, active low |
| pad_out | output | 16 | Pin drive value |
| pad_oe | output | 2 | Drive enable, bit 0 low group, bit 1 high group |
| pad_in | input | 16 | Pin input value |
| done | output | 1 | Final clock of a cycle |
| rd_data | output | 16 | Read data, valid with done |

## Verification
The bound checker watches on every clock that ale never overlaps a strobe, that the high write strobe stays silent in 8-bit mode, and that the chip selects hold steady through a cycle. It also checks that a low ready freezes the strobe phase, that the low group is released whenever the read strobe is low, and that quiet internal accesses leave the strobes high. Exact lane steering, the read data assembly, cycle lengths under each wait setting and stall, and the region decode values can only be shown by the bench scenarios. There a behavioural model predicts every output on every clock.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int WCNT_W = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_END  = 2'd3
  } phase_e;

  typedef struct packed {
    logic byte8;
    logic quiet;
    logic wait_one;
    logic samp;
  } bus_cfg_t;

  // Extra strobe clocks for a given configuration.
  function automatic logic [WCNT_W-1:0] extra_waits(input bus_cfg_t c);
    if (c.wait_one)  return WCNT_W'(1);
    else if (c.samp) return WCNT_W'(2);
    else             return '0;
  endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int CNT_W = WCNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rdy,
  input  logic [CNT_W-1:0] extra,
  output phase_e           phase,
  output logic             cap
);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign cap      = (ph_q == PH_STRB) && rdy && cnt_zero;
  assign phase    = ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) ph_q <= PH_ADDR;
        PH_ADDR: begin
          ph_q  <= PH_STRB;
          cnt_q <= extra;
        end
        PH_STRB: begin
          if (rdy) begin
            if (!cnt_zero) cnt_q <= cnt_q - CNT_W'(1);
            else           ph_q  <= PH_END;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xbus_cs_decode.sv
module xbus_cs_decode #(
  parameter int ADDR_W = 16,
  parameter int CMP_W  = 4,
  parameter int N_SEL  = 5
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   active,
  input  logic [N_SEL*CMP_W-1:0] base,
  input  logic [N_SEL*CMP_W-1:0] mask,
  output logic [N_SEL-1:0]       sel_n
);

  localparam int TOP = ADDR_W - CMP_W;

  logic [CMP_W-1:0] upper;
  assign upper = addr[ADDR_W-1:TOP];

  for (genvar g = 0; g < N_SEL; g++) begin : g_sel
    logic [CMP_W-1:0] diff;
    assign diff     = (upper ^ base[g*CMP_W +: CMP_W]) & mask[g*CMP_W +: CMP_W];
    assign sel_n[g] = !(active && (diff == '0));
  end

endmodule

// File: rtl/xbus_lanes.sv
module xbus_lanes
  import xbus_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  phase_e              phase,
  input  bus_cfg_t            cfg,
  input  logic                write,
  input  logic [1:0]          be,
  input  logic [2*LANE_W-1:0] addr,
  input  logic [2*LANE_W-1:0] wdata,
  input  logic                internal,
  input  logic                cap,
  input  logic [2*LANE_W-1:0] pad_in,
  output logic                ale,
  output logic                rd_n,
  output logic                wel_n,
  output logic                weh_n,
  output logic [2*LANE_W-1:0] pad_out,
  output logic [1:0]          pad_oe,
  output logic [2*LANE_W-1:0] rd_data
);

  localparam int DW = 2 * LANE_W;

  logic addr_ph, data_ph, act, odd_only;

  assign addr_ph  = (phase == PH_ADDR);
  assign data_ph  = (phase == PH_STRB) || (phase == PH_END);
  assign act      = (phase == PH_STRB) && !(internal && cfg.quiet);
  assign odd_only = (be == 2'b10);

  assign ale   = addr_ph;
  assign rd_n  = !(act && !write);
  assign wel_n = !(act && write && (cfg.byte8 || be[0]));
  assign weh_n = !(act && write && !cfg.byte8 && be[1]);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LANE_W-1:0] a_byte, w_byte, drv;
    logic              en;
    assign a_byte = addr[g*LANE_W +: LANE_W];
    if (g == 0) begin : g_even
      assign w_byte = (cfg.byte8 && odd_only) ? wdata[DW-1:LANE_W] : wdata[LANE_W-1:0];
      always_comb begin
        drv = '0;
        en  = 1'b0;
        if (addr_ph) begin
          drv = a_byte;
          en  = 1'b1;
        end else if (data_ph && write) begin
          drv = w_byte;
          en  = 1'b1;
        end
      end
    end else begin : g_odd
      assign w_byte = wdata[DW-1:LANE_W];
      always_comb begin
        drv = '0;
        en  = 1'b0;
        if (addr_ph || (data_ph && cfg.byte8)) begin
          drv = a_byte;
          en  = 1'b1;
        end else if (data_ph && write) begin
          drv = w_byte;
          en  = 1'b1;
        end
      end
    end
    assign pad_out[g*LANE_W +: LANE_W] = drv;
    assign pad_oe[g]                   = en;
  end

  logic [DW-1:0] rd_asm;
  always_comb begin
    if (internal)       rd_asm = '0;
    else if (!cfg.byte8) rd_asm = pad_in;
    else if (odd_only)  rd_asm = {pad_in[LANE_W-1:0], {LANE_W{1'b0}}};
    else                rd_asm = {{LANE_W{1'b0}}, pad_in[LANE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst)              rd_data <= '0;
    else if (cap && !write) rd_data <= rd_asm;
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int CS_N   = 5,
  parameter int CS_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [2*LANE_W-1:0]    req_addr,
  input  logic                   req_write,
  input  logic [1:0]             req_be,
  input  logic [2*LANE_W-1:0]    req_wdata,
  input  logic                   req_internal,
  input  logic                   byte_mode,
  input  logic                   quiet_int,
  input  logic                   wait_one,
  input  logic                   rdy_samp,
  input  logic                   rdy,
  input  logic [CS_N*CS_W-1:0]   cs_base,
  input  logic [CS_N*CS_W-1:0]   cs_mask,
  output logic                   ale,
  output logic                   rd_n,
  output logic                   wel_n,
  output logic                   weh_n,
  output logic [CS_N-1:0]        cs_n,
  output logic [2*LANE_W-1:0]    pad_out,
  output logic [1:0]             pad_oe,
  input  logic [2*LANE_W-1:0]    pad_in,
  output logic                   done,
  output logic [2*LANE_W-1:0]    rd_data
);

  localparam int DW = 2 * LANE_W;

  phase_e        phase;
  logic          start, cap;
  bus_cfg_t      cfg_q;
  logic [DW-1:0] addr_q, wdata_q;
  logic          write_q, int_q;
  logic [1:0]    be_q;

  assign start = req_valid && (phase == PH_IDLE);
  assign done  = (phase == PH_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      int_q   <= 1'b0;
      be_q    <= '0;
    end else if (start) begin
      cfg_q   <= '{byte8: byte_mode, quiet: quiet_int, wait_one: wait_one, samp: rdy_samp};
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
      int_q   <= req_internal;
      be_q    <= req_be;
    end
  end

  xbus_seq #(.CNT_W(WCNT_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .rdy   (rdy),
    .extra (extra_waits(cfg_q)),
    .phase (phase),
    .cap   (cap)
  );

  xbus_cs_decode #(.ADDR_W(DW), .CMP_W(CS_W), .N_SEL(CS_N)) u_cs (
    .addr   (addr_q),
    .active (phase != PH_IDLE),
    .base   (cs_base),
    .mask   (cs_mask),
    .sel_n  (cs_n)
  );

  xbus_lanes #(.LANE_W(LANE_W)) u_lanes (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .cfg      (cfg_q),
    .write    (write_q),
    .be       (be_q),
    .addr     (addr_q),
    .wdata    (wdata_q),
    .internal (int_q),
    .cap      (cap),
    .pad_in   (pad_in),
    .ale      (ale),
    .rd_n     (rd_n),
    .wel_n    (wel_n),
    .weh_n    (weh_n),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int CS_N = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            ale,
  input logic            rd_n,
  input logic            wel_n,
  input logic            weh_n,
  input logic [CS_N-1:0] cs_n,
  input logic [1:0]      pad_oe,
  input logic            done,
  input logic            rdy,
  input logic [1:0]      phase,
  input logic            byte8,
  input logic            quiet,
  input logic            internal
);

  localparam logic [1:0] P_IDLE = 2'd0;
  localparam logic [1:0] P_STRB = 2'd2;

  assert_ale_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wel_n && weh_n));

  assert_done_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!ale && rd_n && wel_n && weh_n));

  assert_no_high_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !weh_n |-> !byte8);

  assert_read_released_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !pad_oe[0]);

  assert_quiet_internal_R8: assert property (@(posedge clk) disable iff (rst)
    (internal && quiet && phase != P_IDLE) |-> (rd_n && wel_n && weh_n));

  assert_ready_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (phase == P_STRB && !rdy) |=> (phase == P_STRB && $stable({rd_n, wel_n, weh_n})));

  assert_select_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (phase != P_IDLE) |=> (phase == P_IDLE || $stable(cs_n)));

endmodule

bind xbus_ctrl xbus_ctrl_chk #(.CS_N(CS_N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ale      (ale),
  .rd_n     (rd_n),
  .wel_n    (wel_n),
  .weh_n    (weh_n),
  .cs_n     (cs_n),
  .pad_oe   (pad_oe),
  .done     (done),
  .rdy      (rdy),
  .phase    (phase),
  .byte8    (cfg_q.byte8),
  .quiet    (cfg_q.quiet),
  .internal (int_q)
);

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_internal = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, pad_in = '0;
  logic [1:0]  req_be = 2'b11;
  logic        byte_mode = 1'b0, quiet_int = 1'b0, wait_one = 1'b0, rdy_samp = 1'b0, rdy = 1'b1;
  logic [19:0] cs_base, cs_mask;
  logic        ale, rd_n, wel_n, weh_n, done;
  logic [4:0]  cs_n;
  logic [15:0] pad_out, rd_data;
  logic [1:0]  pad_oe;

  // regions: 0 -> 0x0xxx, 1 -> 0x1xxx, 2 -> upper half, 3 -> all, 4 -> 0x4xxx..0x7xxx
  assign cs_base = {4'h4, 4'h0, 4'h8, 4'h1, 4'h0};
  assign cs_mask = {4'hC, 4'h0, 4'h8, 4'hF, 4'hF};

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl u_xbus_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .req_internal(req_internal), .byte_mode(byte_mode), .quiet_int(quiet_int),
    .wait_one(wait_one), .rdy_samp(rdy_samp), .rdy(rdy), .cs_base(cs_base),
    .cs_mask(cs_mask), .ale(ale), .rd_n(rd_n), .wel_n(wel_n), .weh_n(weh_n),
    .cs_n(cs_n), .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in),
    .done(done), .rd_data(rd_data)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_ph = 0;     // 0 idle, 1 address, 2 strobe, 3 end
  int          m_left = 0;
  logic [15:0] m_addr, m_wdata, m_rdata;
  logic        m_wr, m_int, m_b8, m_quiet;
  logic [1:0]  m_be;

  always @(posedge clk) begin
    if (rst) begin
      m_ph <= 0;
    end else begin
      case (m_ph)
        0: if (req_valid) begin
             m_ph <= 1; m_addr <= req_addr; m_wdata <= req_wdata; m_wr <= req_write;
             m_int <= req_internal; m_b8 <= byte_mode; m_quiet <= quiet_int; m_be <= req_be;
             m_left <= wait_one ? 1 : (rdy_samp ? 2 : 0);
           end
        1: m_ph <= 2;
        2: if (rdy) begin
             if (m_left > 0) m_left <= m_left - 1;
             else begin
               m_ph <= 3;
               if (!m_wr) begin
                 if (m_int)              m_rdata <= 16'h0000;
                 else if (!m_b8)         m_rdata <= pad_in;
                 else if (m_be == 2'b10) m_rdata <= {pad_in[7:0], 8'h00};
                 else                    m_rdata <= {8'h00, pad_in[7:0]};
               end
             end
           end
        default: m_ph <= 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      logic act;
      logic [2:0] e_strb;
      logic [4:0] e_cs;
      logic [15:0] e_out;
      logic [1:0] e_oe;
      string t;
      act = (m_ph == 2) && !(m_int && m_quiet);
      e_strb = {!(act && !m_wr), !(act && m_wr && (m_b8 || m_be[0])), !(act && m_wr && !m_b8 && m_be[1])};
      for (int i = 0; i < 5; i++) begin
        logic [3:0] d;
        d = (m_addr[15:12] ^ cs_base[i*4 +: 4]) & cs_mask[i*4 +: 4];
        e_cs[i] = !((m_ph != 0) && (d == 4'h0));
      end
      e_out = 16'h0; e_oe = 2'b00;
      if (m_ph == 1) begin e_out = m_addr; e_oe = 2'b11; end
      else if (m_ph >= 2) begin
        if (m_b8) begin
          e_out[15:8] = m_addr[15:8];
          if (m_wr) begin e_out[7:0] = (m_be == 2'b10) ? m_wdata[15:8] : m_wdata[7:0]; e_oe = 2'b11; end
          else e_oe = 2'b10;
        end else if (m_wr) begin e_out = m_wdata; e_oe = 2'b11; end
      end
      chk(ale == (m_ph == 1), "R2 ale", ale, m_ph == 1);
      chk(done == (m_ph == 3), "R2 done", done, m_ph == 3);
      t = m_b8 ? "R5 strobes" : (m_int ? "R8 strobes" : "R4 strobes");
      chk({rd_n, wel_n, weh_n} == e_strb, t, {rd_n, wel_n, weh_n}, e_strb);
      chk(cs_n == e_cs, "R11 cs_n", cs_n, e_cs);
      t = (m_ph == 1) ? "R3 pads" : (m_b8 ? (m_wr ? "R5 pads" : "R7 pads") : (m_wr ? "R12 pads" : "R6 pads"));
      chk({pad_oe, pad_out} == {e_oe, e_out}, t, {pad_oe, pad_out}, {e_oe, e_out});
      if (m_ph == 3 && !m_wr) begin
        t = m_int ? "R8 rd_data" : (m_b8 ? "R7 rd_data" : "R6 rd_data");
        chk(rd_data == m_rdata, t, rd_data, m_rdata);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic run(input logic [15:0] a, input logic wr, input logic [1:0] be,
                     input logic [15:0] wd, input logic intl, input logic b8,
                     input logic q, input logic w1, input logic sp,
                     input int stall_at, input int stall_len, input logic [15:0] pin);
    int k, expk, extra;
    string tag;
    @(negedge clk);
    req_addr = a; req_write = wr; req_be = be; req_wdata = wd; req_internal = intl;
    byte_mode = b8; quiet_int = q; wait_one = w1; rdy_samp = sp; pad_in = pin;
    req_valid = 1'b1;
    extra = w1 ? 1 : (sp ? 2 : 0);
    expk = 3 + extra + stall_len;
    k = 0;
    rdy = !(stall_len > 0 && k >= stall_at && k < stall_at + stall_len);
    while (1) begin
      @(negedge clk);
      k++;
      rdy = !(stall_len > 0 && k >= stall_at && k < stall_at + stall_len);
      if (k == 1) req_valid = 1'b0;
      if (done || k > 100) break;
    end
    rdy = 1'b1;
    tag = (stall_len > 0) ? "R10 length" : ((extra > 0) ? "R9 length" : "R2 length");
    chk(k == expk, tag, k, expk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({ale, rd_n, wel_n, weh_n, done} == 5'b01110, "R1 strobes", {ale, rd_n, wel_n, weh_n, done}, 5'b01110);
    chk(cs_n == 5'h1F, "R1 cs_n", cs_n, 5'h1F);
    chk({pad_oe, pad_out} == 18'h0, "R1 pads", {pad_oe, pad_out}, 0);
    rst = 1'b0;
    // R6 R3: 16-bit external read, no waits
    run(16'h1234, 0, 2'b11, 16'h0, 0, 0, 0, 0, 0, 0, 0, 16'hBEEF);
    // R4 R12: 16-bit word, even and odd byte writes
    run(16'h0A10, 1, 2'b11, 16'h8ACE, 0, 0, 0, 0, 0, 0, 0, 16'h0);
    run(16'h9002, 1, 2'b01, 16'h1155, 0, 0, 0, 0, 0, 0, 0, 16'h0);
    run(16'h5003, 1, 2'b10, 16'hA700, 0, 0, 0, 0, 0, 0, 0, 16'h0);
    // R5 R7: 8-bit bus
    run(16'h6F21, 1, 2'b10, 16'h3C00, 0, 1, 0, 0, 0, 0, 0, 16'h0);
    run(16'h6F20, 1, 2'b01, 16'h00D4, 0, 1, 0, 0, 0, 0, 0, 16'h0);
    run(16'h2345, 0, 2'b10, 16'h0, 0, 1, 0, 0, 0, 0, 0, 16'h77E1);
    run(16'h2344, 0, 2'b01, 16'h0, 0, 1, 0, 0, 0, 0, 0, 16'h6612);
    // R9: wait settings
    run(16'hC000, 0, 2'b11, 16'h0, 0, 0, 0, 1, 0, 0, 0, 16'h4321);
    run(16'hC002, 1, 2'b11, 16'h9999, 0, 0, 0, 0, 1, 0, 0, 16'h0);
    run(16'hC004, 0, 2'b11, 16'h0, 0, 0, 0, 1, 1, 0, 0, 16'h0F0F);
    // R10: ready stalls, alone and during waits
    run(16'h1100, 0, 2'b11, 16'h0, 0, 0, 0, 0, 0, 2, 3, 16'h5A5A);
    run(16'h1102, 1, 2'b11, 16'hCAFE, 0, 0, 0, 0, 1, 3, 2, 16'h0);
    // R8: internal accesses
    run(16'h0040, 0, 2'b11, 16'h0, 1, 0, 1, 0, 0, 0, 0, 16'hFFFF);
    run(16'h0042, 1, 2'b11, 16'h1234, 1, 0, 1, 0, 0, 0, 0, 16'h0);
    run(16'h0044, 0, 2'b11, 16'h0, 1, 0, 0, 0, 0, 0, 0, 16'hABCD);
    // R11: region decode spread
    run(16'h7FFE, 0, 2'b11, 16'h0, 0, 0, 0, 0, 0, 0, 0, 16'h1357);
    run(16'hFFFE, 1, 2'b11, 16'h2468, 0, 0, 0, 0, 0, 0, 0, 16'h0);
    run(16'h3000, 0, 2'b11, 16'h0, 0, 0, 0, 0, 0, 0, 0, 16'h8642);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule